// File: doc/BRIEF.md
# Peripheral I/O Port Decoder

This block sits between a CPU's I/O cycles and a shared 8-bit peripheral bus. Two peripherals sit on that bus. The first is a USB host controller with two registers, chosen by a register-select line. The second is a network controller with a 10-bit register address. Every port the block answers has the low address byte `0xAB`. The high address byte chooses what the CPU reaches:

- a local configuration register;
- a local upper-address map register;
- the USB controller's index register;
- a data port. Depending on a configuration bit, the data port reaches either the USB controller's data register or the network controller.

When the data port routes to the network controller, the CPU's upper address byte supplies network address bits 5:0. The map register supplies bits 9:6. A configuration bit can invert address bit 0. Each recognised peripheral access runs as a short sequence. The chip select comes first, the read or write strobe follows, and the strobe is released one cycle before the chip select. Read data from the selected peripheral, or from a local register, is driven back to the CPU while the access lasts. The configuration register also drives the USB controller's mode pin, and its top bit reports a live power-sense input.

Top module: `ioPortDecoder`

## Requirements
- R1: After reset, both chip selects and both peripheral strobes are high, the CPU data enable is low, and the configuration and map registers hold zero.
- R2: A write to port `0x82AB` stores bits 6 and 4:0 of the data. Reading the port returns those bits as written, bit 5 as 0, and bit 7 as the live level of `powerSense`.
- R3: A write to port `0x81AB` stores data bits 3:0. Reading the port returns them in bits 3:0, with bits 7:4 as 0.
- R4: `usbModeN` is the inverse of configuration bit 6, and it is held high whenever `rstN` is low.
- R5: An access to port `0x80AB` selects the USB controller with `usbRegSel` = 0, whatever the state of configuration bit 4.
- R6: With configuration bit 4 clear, an access to any port whose address bit 15 is 0 and whose low byte is `0xAB` selects the USB controller with `usbRegSel` = 1.
- R7: With configuration bit 4 set, that same data-port access selects the network controller instead. `netAddr` = {map bits 3:0, CPU address bits 13:8}, with bit 0 XORed with configuration bit 3.
- R8: An access whose low byte is not `0xAB`, or whose high byte has bit 7 set but is not `0x80`, `0x81` or `0x82`, raises no chip select, no strobe and no CPU data enable.
- R9: On a peripheral read, `perRdN` pulses low and `cpuDataOut` carries `perRdData` with `cpuDataOe` high. On a peripheral write, `perWrN` pulses low and `perWrData` carries the written byte with `perWrOe` high. Read and write strobes are never low together.
- R10: At most one chip select is low at a time. The chip select goes low the cycle after the request is seen, and the strobe goes low one cycle after that. When the request ends, the strobe rises one cycle before the chip select.
- R11: An access to a local register (`0x81AB` or `0x82AB`) raises no peripheral chip select or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuDataIn | input | 8 | CPU write data |
| cpuDataOut | output | 8 | Read data back to the CPU |
| cpuDataOe | output | 1 | Enable for driving `cpuDataOut` onto the CPU bus |
| ioReqN | input | 1 | Active-low CPU I/O request |
| rdN | input | 1 | Active-low CPU read |
| wrN | input | 1 | Active-low CPU write |
| perRdData | input | 8 | Read data from the peripheral bus |
| perWrData | output | 8 | Write data to the peripheral bus |
| perWrOe | output | 1 | Enable for driving `perWrData` onto the peripheral bus |
| perRdN | output | 1 | Active-low peripheral read strobe |
| perWrN | output | 1 | Active-low peripheral write strobe |
| usbCsN | output | 1 | Active-low USB controller chip select |
| usbRegSel | output | 1 | USB register select (0 index, 1 data) |
| netCsN | output | 1 | Active-low network controller chip select |
| netAddr | output | 10 | Network controller register address |
| usbModeN | output | 1 | Active-low USB controller mode select |
| powerSense | input | 1 | Live power-sense input |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, a 10-bit network address and a 4-bit map field. With these values every port decode is reachable, including the case where the data port switches between the two peripherals. Two map and address patterns, one with the bit-0 inversion on and one with it off, exercise the 6/4 split of the network address. Each access is sampled in its setup, strobe, hold and idle cycles, so the ordering of chip select and strobe is observed directly on the pins.

// File: rtl/ioDecodePkg.sv
package ioDecodePkg;
  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_CFG,
    TGT_MAP,
    TGT_USB_IDX,
    TGT_USB_DAT,
    TGT_NET
  } ioTarget_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      capture;
    logic      cfgWr;
    logic      mapWr;
    logic      busy;
    logic      isRead;
    ioTarget_e target;
  } ctlStrobes_t;
endpackage

// File: rtl/ioDecodeCtrl.sv
module ioDecodeCtrl
  import ioDecodePkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [7:0]  PORT_LO    = 8'hAB,
  parameter logic [7:0]  CFG_HI     = 8'h82,
  parameter logic [7:0]  MAP_HI     = 8'h81,
  parameter logic [7:0]  USB_IDX_HI = 8'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioReqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              netEn,
  output ctlStrobes_t       ctl,
  output logic              usbCsN,
  output logic              usbRegSel,
  output logic              netCsN,
  output logic              perRdN,
  output logic              perWrN
);
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} state_e;

  state_e    state, stateNext;
  ioTarget_e tgtQ, tgtDec;
  logic      readQ;
  logic      reqNow;
  logic [7:0] hiByte, loByte;

  assign reqNow = !ioReqN && (!rdN || !wrN);
  assign hiByte = cpuAddr[ADDR_W-1 -: 8];
  assign loByte = cpuAddr[7:0];

  always_comb begin
    tgtDec = TGT_NONE;
    if (loByte == PORT_LO) begin
      if (hiByte == CFG_HI)                tgtDec = TGT_CFG;
      else if (hiByte == MAP_HI)           tgtDec = TGT_MAP;
      else if (hiByte == USB_IDX_HI)       tgtDec = TGT_USB_IDX;
      else if (!cpuAddr[ADDR_W-1])         tgtDec = netEn ? TGT_NET : TGT_USB_DAT;
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqNow) stateNext = ST_SETUP;
      ST_SETUP:  stateNext = ST_STROBE;
      ST_STROBE: if (!reqNow) stateNext = ST_HOLD;
      ST_HOLD:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tgtQ  <= TGT_NONE;
      readQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqNow) begin
        tgtQ  <= tgtDec;
        readQ <= !rdN;
      end
    end
  end

  logic csOn, strbOn, usbSel, netSel;
  assign csOn   = (state != ST_IDLE);
  assign strbOn = (state == ST_STROBE);
  assign usbSel = (tgtQ == TGT_USB_IDX) || (tgtQ == TGT_USB_DAT);
  assign netSel = (tgtQ == TGT_NET);

  assign usbCsN    = !(csOn && usbSel);
  assign netCsN    = !(csOn && netSel);
  assign usbRegSel = (tgtQ == TGT_USB_DAT);
  assign perRdN    = !(strbOn && (usbSel || netSel) && readQ);
  assign perWrN    = !(strbOn && (usbSel || netSel) && !readQ);

  assign ctl.capture = (state == ST_IDLE) && reqNow;
  assign ctl.busy    = csOn;
  assign ctl.isRead  = readQ;
  assign ctl.target  = tgtQ;
  assign ctl.cfgWr   = (state == ST_SETUP) && !readQ && (tgtQ == TGT_CFG);
  assign ctl.mapWr   = (state == ST_SETUP) && !readQ && (tgtQ == TGT_MAP);
endmodule

// File: rtl/ioDecodeDatapath.sv
module ioDecodeDatapath
  import ioDecodePkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int NET_AW  = 10,
  parameter int MAP_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuDataIn,
  input  logic [DATA_W-1:0] perRdData,
  input  logic              powerSense,
  output logic [DATA_W-1:0] cpuDataOut,
  output logic              cpuDataOe,
  output logic [DATA_W-1:0] perWrData,
  output logic              perWrOe,
  output logic [NET_AW-1:0] netAddr,
  output logic              netEn,
  output logic              usbModeN
);
  localparam int NET_LO_W   = NET_AW - MAP_W;
  localparam int BIT_INV    = 3;
  localparam int BIT_NETEN  = 4;
  localparam int BIT_MODE   = 6;
  localparam int BIT_PWR    = 7;
  localparam logic [DATA_W-1:0] CFG_KEEP = DATA_W'(8'h5F);

  logic [DATA_W-1:0]   cfgQ;
  logic [MAP_W-1:0]    mapQ;
  logic [NET_LO_W-1:0] addrLoQ;
  logic [DATA_W-1:0]   wrDataQ;
  logic [DATA_W-1:0]   cfgView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ    <= '0;
      mapQ    <= '0;
      addrLoQ <= '0;
      wrDataQ <= '0;
    end else begin
      if (ctl.capture) begin
        addrLoQ <= cpuAddr[8 +: NET_LO_W];
        wrDataQ <= cpuDataIn;
      end
      if (ctl.cfgWr) cfgQ <= wrDataQ & CFG_KEEP;
      if (ctl.mapWr) mapQ <= wrDataQ[MAP_W-1:0];
    end
  end

  assign netEn = cfgQ[BIT_NETEN];
  assign netAddr = {mapQ, addrLoQ} ^ NET_AW'(cfgQ[BIT_INV]);
  assign usbModeN = !rstN || !cfgQ[BIT_MODE];

  always_comb begin
    cfgView          = cfgQ;
    cfgView[BIT_PWR] = powerSense;
  end

  always_comb begin
    unique case (ctl.target)
      TGT_CFG: cpuDataOut = cfgView;
      TGT_MAP: cpuDataOut = DATA_W'(mapQ);
      default: cpuDataOut = perRdData;
    endcase
  end

  logic periph;
  assign periph    = (ctl.target == TGT_USB_IDX) || (ctl.target == TGT_USB_DAT) ||
                     (ctl.target == TGT_NET);
  assign cpuDataOe = ctl.busy && ctl.isRead && (ctl.target != TGT_NONE);
  assign perWrData = wrDataQ;
  assign perWrOe   = ctl.busy && !ctl.isRead && periph;
endmodule

// File: rtl/ioPortDecoder.sv
module ioPortDecoder
  import ioDecodePkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NET_AW = 10,
  parameter int MAP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuDataIn,
  output logic [DATA_W-1:0] cpuDataOut,
  output logic              cpuDataOe,
  input  logic              ioReqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] perRdData,
  output logic [DATA_W-1:0] perWrData,
  output logic              perWrOe,
  output logic              perRdN,
  output logic              perWrN,
  output logic              usbCsN,
  output logic              usbRegSel,
  output logic              netCsN,
  output logic [NET_AW-1:0] netAddr,
  output logic              usbModeN,
  input  logic              powerSense
);
  ctlStrobes_t ctl;
  logic        netEn;

  ioDecodeCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ioReqN(ioReqN), .rdN(rdN), .wrN(wrN),
    .cpuAddr(cpuAddr), .netEn(netEn), .ctl(ctl),
    .usbCsN(usbCsN), .usbRegSel(usbRegSel), .netCsN(netCsN),
    .perRdN(perRdN), .perWrN(perWrN)
  );

  ioDecodeDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NET_AW(NET_AW), .MAP_W(MAP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .perRdData(perRdData), .powerSense(powerSense),
    .cpuDataOut(cpuDataOut), .cpuDataOe(cpuDataOe),
    .perWrData(perWrData), .perWrOe(perWrOe),
    .netAddr(netAddr), .netEn(netEn), .usbModeN(usbModeN)
  );
endmodule

// File: rtl/ioDecodeChecker.sv
module ioDecodeChecker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NET_AW = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuDataOe,
  input logic              perWrOe,
  input logic              perRdN,
  input logic              perWrN,
  input logic              usbCsN,
  input logic              netCsN,
  input logic              usbModeN
);
  logic csAct, strbAct;
  assign csAct   = !usbCsN || !netCsN;
  assign strbAct = !perRdN || !perWrN;

  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !(!usbCsN && !netCsN)); // R10
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rstN)
    strbAct |-> csAct); // R10
  AST_CS_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strbAct) |-> $past(csAct)); // R10
  AST_CS_TRAILS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strbAct) |-> csAct); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!perRdN && !perWrN)); // R9
  AST_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuDataOe && perWrOe)); // R9

  always @(negedge clk) begin
    if (rstN === 1'b0) begin
      AST_MODE_IN_RESET: assert (usbModeN === 1'b1); // R4
    end
  end
endmodule

bind ioPortDecoder ioDecodeChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NET_AW(NET_AW)) u_chk (
  .clk(clk), .rstN(rstN), .cpuDataOe(cpuDataOe), .perWrOe(perWrOe),
  .perRdN(perRdN), .perWrN(perWrN), .usbCsN(usbCsN), .netCsN(netCsN),
  .usbModeN(usbModeN)
);

// File: tb/ioPortDecoder_bench.sv
module ioPortDecoder_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuDataIn = '0;
  logic [7:0]  cpuDataOut;
  logic        cpuDataOe;
  logic        ioReqN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0]  perRdData = '0;
  logic [7:0]  perWrData;
  logic        perWrOe, perRdN, perWrN, usbCsN, usbRegSel, netCsN, usbModeN;
  logic [9:0]  netAddr;
  logic        powerSense = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioPortDecoder u_ioPortDecoder (.*);

  // snapshots of one access
  logic sCsSetup, sStrbSetup;
  logic sUsbCs, sNetCs, sRegSel, sRdN, sWrN, sOe, sWrOe;
  logic [7:0] sRdData, sWrData;
  logic [9:0] sNetAddr;
  logic hCs, hStrb, aCs;

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic ioCycle(input logic [15:0] addr, input logic isRead, input logic [7:0] wdata);
    @(negedge clk);
    cpuAddr = addr; cpuDataIn = wdata; ioReqN = 1'b0;
    rdN = !isRead; wrN = isRead;
    @(negedge clk);
    sCsSetup   = !usbCsN || !netCsN;
    sStrbSetup = !perRdN || !perWrN;
    @(negedge clk);
    sUsbCs = !usbCsN; sNetCs = !netCsN; sRegSel = usbRegSel;
    sRdN = perRdN; sWrN = perWrN; sOe = cpuDataOe; sWrOe = perWrOe;
    sRdData = cpuDataOut; sWrData = perWrData; sNetAddr = netAddr;
    @(negedge clk);
    ioReqN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    @(negedge clk);
    hCs = !usbCsN || !netCsN; hStrb = !perRdN || !perWrN;
    @(negedge clk);
    aCs = !usbCsN || !netCsN;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1", "usbCsN", usbCsN, 1); chk("R1", "netCsN", netCsN, 1);
    chk("R1", "perRdN", perRdN, 1); chk("R1", "perWrN", perWrN, 1);
    chk("R1", "cpuDataOe", cpuDataOe, 0);
    chk("R4", "usbModeN in reset", usbModeN, 1);
    rstN = 1'b1;
    ioCycle(16'h82AB, 1, 0); chk("R1", "cfg after reset", sRdData, 8'h00);
    ioCycle(16'h81AB, 1, 0); chk("R1", "map after reset", sRdData, 8'h00);
  endtask

  task automatic testConfigRegs();
    ioCycle(16'h82AB, 0, 8'hFF);
    chk("R11", "no cs on cfg write", {sUsbCs, sNetCs, sRdN, sWrN}, 4'b0011);
    powerSense = 1'b1;
    ioCycle(16'h82AB, 1, 0);
    chk("R2", "cfg readback ff", sRdData, 8'hDF);
    chk("R2", "cfg read oe", sOe, 1);
    chk("R11", "no cs on cfg read", {sUsbCs, sNetCs}, 2'b00);
    powerSense = 1'b0;
    ioCycle(16'h82AB, 0, 8'h0A);
    ioCycle(16'h82AB, 1, 0);
    chk("R2", "cfg readback 0a", sRdData, 8'h0A);
  endtask

  task automatic testMapReg();
    ioCycle(16'h81AB, 0, 8'hF6);
    chk("R11", "no cs on map write", {sUsbCs, sNetCs}, 2'b00);
    ioCycle(16'h81AB, 1, 0);
    chk("R3", "map readback", sRdData, 8'h06);
  endtask

  task automatic testUsbMode();
    ioCycle(16'h82AB, 0, 8'h40);
    chk("R4", "usbModeN bit6=1", usbModeN, 0);
    ioCycle(16'h82AB, 0, 8'h00);
    chk("R4", "usbModeN bit6=0", usbModeN, 1);
    ioCycle(16'h82AB, 0, 8'h40);
    @(negedge clk); rstN = 1'b0;
    #1 chk("R4", "usbModeN forced in reset", usbModeN, 1);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testUsbPorts();
    ioCycle(16'h80AB, 0, 8'h5A);
    chk("R5", "usb idx write cs", sUsbCs, 1);
    chk("R5", "usb idx regsel", sRegSel, 0);
    chk("R9", "write strobe", {sRdN, sWrN}, 2'b10);
    chk("R9", "write data", sWrData, 8'h5A);
    chk("R9", "write oe", sWrOe, 1);
    perRdData = 8'hC3;
    ioCycle(16'h7FAB, 1, 0);
    chk("R6", "usb data cs", {sUsbCs, sNetCs}, 2'b10);
    chk("R6", "usb data regsel", sRegSel, 1);
    chk("R9", "read strobe", {sRdN, sWrN}, 2'b01);
    chk("R9", "read data", sRdData, 8'hC3);
    chk("R9", "read oe", sOe, 1);
    chk("R10", "cs before strobe", {sCsSetup, sStrbSetup}, 2'b10);
    chk("R10", "strobe off before cs", {hCs, hStrb}, 2'b10);
    chk("R10", "cs off after hold", aCs, 0);
  endtask

  task automatic testNetPort();
    ioCycle(16'h81AB, 0, 8'h0A);
    ioCycle(16'h82AB, 0, 8'h18);
    ioCycle(16'h3DAB, 0, 8'h77);
    chk("R7", "net cs", {sUsbCs, sNetCs}, 2'b01);
    chk("R7", "net addr inverted", sNetAddr, 10'h2BC);
    chk("R9", "net write data", sWrData, 8'h77);
    ioCycle(16'h81AB, 0, 8'h05);
    ioCycle(16'h82AB, 0, 8'h10);
    perRdData = 8'h3E;
    ioCycle(16'h42AB, 1, 0);
    chk("R7", "net addr plain", sNetAddr, 10'h142);
    chk("R9", "net read data", sRdData, 8'h3E);
    ioCycle(16'h80AB, 1, 0);
    chk("R5", "idx port with net enabled", {sUsbCs, sNetCs, sRegSel}, 3'b100);
    ioCycle(16'h82AB, 0, 8'h00);
  endtask

  task automatic testIgnored();
    ioCycle(16'h83AB, 1, 0);
    chk("R8", "0x83AB no cs/strobe", {sUsbCs, sNetCs, sRdN, sWrN, sOe}, 5'b00110);
    ioCycle(16'h12AC, 0, 8'h11);
    chk("R8", "bad low byte", {sUsbCs, sNetCs, sRdN, sWrN, sWrOe}, 5'b00110);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testConfigRegs();
    testMapReg();
    testUsbMode();
    testUsbPorts();
    testNetPort();
    testIgnored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule